// File: doc/BRIEF.md
# Clock-Detect Power-Up Sequencer

This block controls power-up for an audio converter. It runs on a free-running system clock and watches two slower clocks: the master clock and the frame (left/right) clock. While either one is missing, the converter is held powered down. In that state the filter/modulator reset is asserted and every analog enable is off.

Once both clocks are toggling, the block measures how many master-clock rising edges fall within one frame period. It maps that count to one of three supported ratios. It then brings the converter up in a fixed order:
1. Voltage reference on.
2. Supply mode taken from two range flags.
3. Converters and switched-capacitor filters on.
4. Ready flag raised after a settling interval.

Losing either clock sends the block straight back to power-down. The next start measures the ratio and samples the supply flags again.

Top module: `pwrup_seq`

## Requirements
- R1: While reset is asserted and right after it, `mod_rst_o` is 1 and `ref_en_o`, `dac_en_o`, `filt_en_o`, `ready_o` and `ratio_err_o` are 0.
- R2: The block stays powered down (reference off, modulator reset on) while either clock shows no edges, including when only the master clock runs.
- R3: The master-clock rising edges between two consecutive frame-clock rising edges are counted. A count within ±`RATIO_TOL` of 256, 384 or 512 gives `ratio_o` = 0, 1 or 2 respectively. `ratio_o` holds its value while the reference is on.
- R4: The reference enable rises first. `dac_en_o` and `filt_en_o` rise only while the reference is already on. `mod_rst_o` drops at that same point.
- R5: The supply mode is sampled while the reference is on. `sup5_o` becomes 1 if `sup_hi_i` is 1, otherwise 0 if `sup_lo_i` is 1; the high flag wins when both are set. The bit holds while the converters are on.
- R6: `ready_o` rises only after the converters have been on for `SETTLE_CYC` system cycles followed by `FRAME_WAIT` frame-clock rising edges.
- R7: A clock counts as lost after `MCLK_TMO` (master) or `FCLK_TMO` (frame) system cycles without an edge. On the next cycle the block is back in power-down with `ready_o` low.
- R8: Each exit from power-down repeats the ratio measurement and the supply sampling, so a new ratio or supply range takes effect.
- R9: A count matching no supported ratio sets `ratio_err_o`, and the block stays with the reference and converters off. The flag clears when the next measurement starts.
- R10: If neither supply flag is set, the block stays with only the reference on until a flag appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mclk_i | input | 1 | Master clock (asynchronous) |
| fclk_i | input | 1 | Frame clock (asynchronous) |
| sup_hi_i | input | 1 | Supply in the high (5 V) range |
| sup_lo_i | input | 1 | Supply in the low (3 V) range |
| mod_rst_o | output | 1 | Filter/modulator reset |
| ref_en_o | output | 1 | Voltage reference enable |
| dac_en_o | output | 1 | Converter enable |
| filt_en_o | output | 1 | Switched-capacitor filter enable |
| ready_o | output | 1 | Output settled and valid |
| ratio_o | output | 2 | Ratio code: 0=256, 1=384, 2=512 |
| sup5_o | output | 1 | 1 = 5 V mode, 0 = 3 V mode |
| ratio_err_o | output | 1 | Measured ratio unsupported |

## Verification
The assertions check the following on every cycle:
- The enable ordering and the reference-before-converter dependency.
- A one-cycle drop to power-down after a clock is lost.
- The hold of the ratio code and supply bit while the block is powered.
- The lock-out under a ratio error or a missing supply flag.

Only the bench scenarios can show:
- That the measured count maps to the right code for each frame length.
- That the settling interval really spans the system-cycle wait plus the frame count.
- That a restart adopts a new ratio and a new supply range.
- That loss is detected within the timeout.

// File: rtl/pwrup_seq_pkg.sv
package pwrup_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_MEAS,
    ST_REF,
    ST_CONV,
    ST_READY,
    ST_FAULT
  } seq_state_e;

  typedef enum logic [1:0] {
    RATIO_256  = 2'd0,
    RATIO_384  = 2'd1,
    RATIO_512  = 2'd2,
    RATIO_NONE = 2'd3
  } ratio_code_e;

  localparam int NUM_RATIOS = 3;
  localparam int MAX_RATIO  = 512;

  function automatic int ratio_nominal(input int idx);
    case (idx)
      0:       return 256;
      1:       return 384;
      default: return 512;
    endcase
  endfunction

endpackage

// File: rtl/pwrup_clk_presence.sv
module pwrup_clk_presence #(
  parameter int TMO         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clk_async_i,
  output logic rise_o,
  output logic alive_o
);
  localparam int TW = $clog2(TMO + 1);

  logic [SYNC_STAGES:0] sync_q;
  logic [TW-1:0]        tmo_q;
  logic                 alive_q;
  logic                 s_now, s_prev, any_edge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-1:0], clk_async_i};
  end

  assign s_now    = sync_q[SYNC_STAGES-1];
  assign s_prev   = sync_q[SYNC_STAGES];
  assign any_edge = s_now ^ s_prev;
  assign rise_o   = s_now & ~s_prev;

  // edge restarts the timeout; expiry marks the clock as gone
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmo_q   <= '0;
      alive_q <= 1'b0;
    end else if (any_edge) begin
      tmo_q   <= '0;
      alive_q <= 1'b1;
    end else if (tmo_q == TW'(TMO - 1)) begin
      alive_q <= 1'b0;
    end else begin
      tmo_q <= tmo_q + 1'b1;
    end
  end

  assign alive_o = alive_q;
endmodule

// File: rtl/pwrup_ratio_meas.sv
module pwrup_ratio_meas
  import pwrup_seq_pkg::*;
#(
  parameter int RATIO_TOL = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        abort_i,
  input  logic        mrise_i,
  input  logic        frise_i,
  output logic        done_o,
  output ratio_code_e code_o,
  output logic        err_o
);
  localparam int CNT_W = $clog2(MAX_RATIO + RATIO_TOL + 2);

  typedef enum logic [1:0] {M_IDLE, M_ARM, M_CNT} meas_e;

  meas_e             mst_q;
  logic [CNT_W-1:0]  cnt_q, fin;
  logic              hit;
  ratio_code_e       code_c;
  logic              done_q, err_q;
  ratio_code_e       code_q;

  // count including a master edge coincident with the closing frame edge
  always_comb begin
    if (mrise_i && (cnt_q != '1)) fin = cnt_q + 1'b1;
    else                          fin = cnt_q;
  end

  always_comb begin
    hit    = 1'b0;
    code_c = RATIO_NONE;
    for (int i = 0; i < NUM_RATIOS; i++) begin
      if (int'(fin) >= ratio_nominal(i) - RATIO_TOL &&
          int'(fin) <= ratio_nominal(i) + RATIO_TOL) begin
        hit    = 1'b1;
        code_c = ratio_code_e'(2'(i));
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mst_q  <= M_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      code_q <= RATIO_NONE;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        mst_q <= M_IDLE;
      end else if (start_i) begin
        mst_q <= M_ARM;
        cnt_q <= '0;
      end else begin
        case (mst_q)
          M_ARM: if (frise_i) begin
            mst_q <= M_CNT;
            cnt_q <= '0;
          end
          M_CNT: if (frise_i) begin
            mst_q  <= M_IDLE;
            done_q <= 1'b1;
            err_q  <= ~hit;
            code_q <= code_c;
          end else begin
            cnt_q <= fin;
          end
          default: ;
        endcase
      end
    end
  end

  assign done_o = done_q;
  assign code_o = code_q;
  assign err_o  = err_q;
endmodule

// File: rtl/pwrup_ctrl_fsm.sv
module pwrup_ctrl_fsm
  import pwrup_seq_pkg::*;
#(
  parameter int SETTLE_CYC = 100000,
  parameter int FRAME_WAIT = 1024
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clk_ok_i,
  input  logic        frise_i,
  input  logic        meas_done_i,
  input  ratio_code_e meas_code_i,
  input  logic        meas_err_i,
  input  logic        sup_hi_i,
  input  logic        sup_lo_i,
  output logic        meas_start_o,
  output logic        meas_abort_o,
  output logic        mod_rst_o,
  output logic        ref_en_o,
  output logic        conv_en_o,
  output logic        ready_o,
  output ratio_code_e ratio_o,
  output logic        sup5_o,
  output logic        err_o
);
  localparam int SCW = $clog2(SETTLE_CYC + 1);
  localparam int FCW = $clog2(FRAME_WAIT + 1);

  seq_state_e   st_q, st_d;
  logic [SCW-1:0] settle_q;
  logic [FCW-1:0] frame_q;
  logic           settled_q;
  ratio_code_e    ratio_q;
  logic           sup5_q, err_q;

  assign meas_start_o = (st_q == ST_OFF) && clk_ok_i;
  assign meas_abort_o = !clk_ok_i;

  always_comb begin
    st_d = st_q;
    if (!clk_ok_i) begin
      st_d = ST_OFF;
    end else begin
      case (st_q)
        ST_OFF:  st_d = ST_MEAS;
        ST_MEAS: if (meas_done_i) st_d = meas_err_i ? ST_FAULT : ST_REF;
        ST_REF:  if (sup_hi_i || sup_lo_i) st_d = ST_CONV;
        ST_CONV: if (settled_q && frise_i && frame_q == FCW'(FRAME_WAIT - 1))
                   st_d = ST_READY;
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_OFF;
    else         st_q <= st_d;
  end

  // settle: system-cycle interval first, then frame-clock count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      settle_q  <= '0;
      frame_q   <= '0;
      settled_q <= 1'b0;
    end else if (st_q != ST_CONV) begin
      settle_q  <= '0;
      frame_q   <= '0;
      settled_q <= 1'b0;
    end else if (!settled_q) begin
      if (settle_q == SCW'(SETTLE_CYC - 1)) settled_q <= 1'b1;
      else                                  settle_q  <= settle_q + 1'b1;
    end else if (frise_i) begin
      frame_q <= frame_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_q <= RATIO_256;
      sup5_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (meas_start_o) err_q <= 1'b0;
      else if (clk_ok_i && st_q == ST_MEAS && meas_done_i && meas_err_i) err_q <= 1'b1;

      if (clk_ok_i && st_q == ST_MEAS && meas_done_i && !meas_err_i) ratio_q <= meas_code_i;

      if (clk_ok_i && st_q == ST_REF) begin
        if (sup_hi_i)      sup5_q <= 1'b1;
        else if (sup_lo_i) sup5_q <= 1'b0;
      end
    end
  end

  assign ref_en_o  = (st_q == ST_REF) || (st_q == ST_CONV) || (st_q == ST_READY);
  assign conv_en_o = (st_q == ST_CONV) || (st_q == ST_READY);
  assign mod_rst_o = !conv_en_o;
  assign ready_o   = (st_q == ST_READY);
  assign ratio_o   = ratio_q;
  assign sup5_o    = sup5_q;
  assign err_o     = err_q;
endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
  import pwrup_seq_pkg::*;
#(
  parameter int MCLK_TMO   = 16,
  parameter int FCLK_TMO   = 1100,
  parameter int SETTLE_CYC = 100000,
  parameter int FRAME_WAIT = 1024,
  parameter int RATIO_TOL  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mclk_i,
  input  logic       fclk_i,
  input  logic       sup_hi_i,
  input  logic       sup_lo_i,
  output logic       mod_rst_o,
  output logic       ref_en_o,
  output logic       dac_en_o,
  output logic       filt_en_o,
  output logic       ready_o,
  output logic [1:0] ratio_o,
  output logic       sup5_o,
  output logic       ratio_err_o
);
  localparam int NUM_CLKS = 2;

  logic [NUM_CLKS-1:0] clk_raw, clk_rise, clk_alive;
  logic                clk_ok;
  logic                meas_start, meas_abort, meas_done, meas_err;
  ratio_code_e         meas_code, ratio_c;
  logic                conv_en;

  assign clk_raw = {fclk_i, mclk_i};

  for (genvar g = 0; g < NUM_CLKS; g++) begin : g_det
    localparam int TMO_G = (g == 0) ? MCLK_TMO : FCLK_TMO;
    pwrup_clk_presence #(.TMO(TMO_G)) u_det (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clk_async_i(clk_raw[g]),
      .rise_o     (clk_rise[g]),
      .alive_o    (clk_alive[g])
    );
  end

  assign clk_ok = &clk_alive;

  pwrup_ratio_meas #(.RATIO_TOL(RATIO_TOL)) u_meas (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(meas_start),
    .abort_i(meas_abort),
    .mrise_i(clk_rise[0]),
    .frise_i(clk_rise[1]),
    .done_o (meas_done),
    .code_o (meas_code),
    .err_o  (meas_err)
  );

  pwrup_ctrl_fsm #(.SETTLE_CYC(SETTLE_CYC), .FRAME_WAIT(FRAME_WAIT)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clk_ok_i    (clk_ok),
    .frise_i     (clk_rise[1]),
    .meas_done_i (meas_done),
    .meas_code_i (meas_code),
    .meas_err_i  (meas_err),
    .sup_hi_i    (sup_hi_i),
    .sup_lo_i    (sup_lo_i),
    .meas_start_o(meas_start),
    .meas_abort_o(meas_abort),
    .mod_rst_o   (mod_rst_o),
    .ref_en_o    (ref_en_o),
    .conv_en_o   (conv_en),
    .ready_o     (ready_o),
    .ratio_o     (ratio_c),
    .sup5_o      (sup5_o),
    .err_o       (ratio_err_o)
  );

  assign dac_en_o  = conv_en;
  assign filt_en_o = conv_en;
  assign ratio_o   = ratio_c;
endmodule

// File: rtl/pwrup_seq_chk.sv
module pwrup_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       clk_ok_i,
  input logic       sup_hi_i,
  input logic       sup_lo_i,
  input logic       mod_rst_o,
  input logic       ref_en_o,
  input logic       dac_en_o,
  input logic       filt_en_o,
  input logic       ready_o,
  input logic [1:0] ratio_o,
  input logic       sup5_o,
  input logic       ratio_err_o
);
  p_dac_after_ref_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dac_en_o) |-> $past(ref_en_o));

  p_filt_needs_ref_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    filt_en_o |-> ref_en_o && !mod_rst_o);

  p_ratio_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_en_o && $past(ref_en_o)) |-> $stable(ratio_o));

  p_sup_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dac_en_o && $past(dac_en_o)) |-> $stable(sup5_o));

  p_ready_after_conv_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(dac_en_o));

  p_loss_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_ok_i |=> (mod_rst_o && !ref_en_o && !ready_o));

  p_off_no_clk_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_ok_i && !ref_en_o) |=> !ref_en_o);

  p_err_unpowered_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_err_o |-> (!ref_en_o && !dac_en_o));

  p_no_supply_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_en_o && !dac_en_o && !sup_hi_i && !sup_lo_i) |=> !dac_en_o);
endmodule

bind pwrup_seq pwrup_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clk_ok_i   (clk_ok),
  .sup_hi_i   (sup_hi_i),
  .sup_lo_i   (sup_lo_i),
  .mod_rst_o  (mod_rst_o),
  .ref_en_o   (ref_en_o),
  .dac_en_o   (dac_en_o),
  .filt_en_o  (filt_en_o),
  .ready_o    (ready_o),
  .ratio_o    (ratio_o),
  .sup5_o     (sup5_o),
  .ratio_err_o(ratio_err_o)
);

// File: tb/pwrup_seq_tb.sv
module pwrup_seq_tb;
  localparam int MT     = 16;
  localparam int FT     = 1100;
  localparam int SETTLE = 200;
  localparam int FW     = 4;
  localparam int MPER   = 4;   // master clock period in system cycles

  logic clk = 1'b0, rst_ni = 1'b0;
  logic mclk = 1'b0, fclk = 1'b0;
  logic sup_hi = 1'b0, sup_lo = 1'b0;
  logic mod_rst, ref_en, dac_en, filt_en, ready, sup5, rerr;
  logic [1:0] ratio;

  bit run_m = 0, run_f = 0;
  int half = 128, div = 0;

  int n_chk = 0, n_err = 0, ev_cnt = 0, cyc = 0;
  bit finished = 0;

  typedef struct packed {
    logic        is_err;
    logic [1:0]  code;
    logic        sup5;
    logic [31:0] frame;
  } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  initial forever begin
    #20;
    if (run_m) mclk = ~mclk;
  end

  always @(negedge mclk) begin
    if (run_f) begin
      if (div >= half - 1) begin fclk = ~fclk; div = 0; end
      else div = div + 1;
    end
  end

  pwrup_seq #(.MCLK_TMO(MT), .FCLK_TMO(FT), .SETTLE_CYC(SETTLE),
              .FRAME_WAIT(FW), .RATIO_TOL(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .mclk_i(mclk), .fclk_i(fclk),
    .sup_hi_i(sup_hi), .sup_lo_i(sup_lo), .mod_rst_o(mod_rst),
    .ref_en_o(ref_en), .dac_en_o(dac_en), .filt_en_o(filt_en),
    .ready_o(ready), .ratio_o(ratio), .sup5_o(sup5), .ratio_err_o(rerr));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: pops expectations on ready or error events
  bit rdy_p = 0, err_p = 0, ref_p = 0, dac_p = 0;
  int ref_rise = 0, dac_rise = 0;
  always @(negedge clk) begin
    exp_t it;
    cyc++;
    if (ref_en && !ref_p) ref_rise = cyc;
    if (dac_en && !dac_p) dac_rise = cyc;
    if (ready && !rdy_p) begin
      if (exp_q.size() == 0) chk(0, "R6", "unexpected ready", 1, 0);
      else begin
        int dt, lo_b, hi_b;
        it = exp_q.pop_front();
        chk(!it.is_err, "R9", "ready where error expected", 1, 0);
        chk(ratio == it.code, "R3", "ratio code", ratio, it.code);
        chk(sup5 == it.sup5, "R5", "supply mode", sup5, it.sup5);
        chk(ref_rise < dac_rise && !mod_rst && filt_en, "R4", "power order",
            dac_rise - ref_rise, 1);
        dt   = cyc - dac_rise;
        lo_b = SETTLE + (FW - 1) * int'(it.frame);
        hi_b = SETTLE + FW * int'(it.frame) + 8;
        chk(dt >= lo_b && dt <= hi_b, "R6", "settle cycles", dt, lo_b);
      end
      ev_cnt++;
    end
    if (rerr && !err_p) begin
      if (exp_q.size() == 0) chk(0, "R9", "unexpected ratio error", 1, 0);
      else begin
        it = exp_q.pop_front();
        chk(it.is_err, "R9", "ratio error flag", 1, int'(it.is_err));
        chk(!ref_en && !dac_en, "R9", "powered during error", int'(ref_en), 0);
      end
      ev_cnt++;
    end
    rdy_p = ready; err_p = rerr; ref_p = ref_en; dac_p = dac_en;
  end

  task automatic start_clk(input int h, input bit hi, input bit lo,
                           input bit push, input bit is_err, input logic [1:0] code);
    exp_t it;
    if (push) begin
      it.is_err = is_err; it.code = code; it.sup5 = hi;
      it.frame  = 32'(2 * h * MPER);
      exp_q.push_back(it);
    end
    sup_hi = hi; sup_lo = lo;
    half = h; div = 0;
    run_m = 1; run_f = 1;
  endtask

  task automatic wait_ev(input int target, input string req);
    int n = 0;
    while (ev_cnt < target && n < 40000) begin @(negedge clk); n++; end
    chk(ev_cnt >= target, req, "event arrival", ev_cnt, target);
  endtask

  task automatic stop_clk(input bit master, input string req);
    int n = 0;
    int lim;
    lim = master ? MT + 6 : FT + 6;
    if (master) run_m = 0;
    run_f = 0;
    while (!(mod_rst && !ref_en && !ready) && n < 3 * FT) begin @(negedge clk); n++; end
    chk(n <= lim, req, "cycles to power-down", n, lim);
    run_m = 0;
    repeat (FT + 20) @(negedge clk);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(mod_rst && !ref_en && !dac_en && !filt_en && !ready && !rerr,
        "R1", "state in reset", int'(ref_en), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(mod_rst && !ref_en && !dac_en && !ready, "R1", "state after reset", int'(mod_rst), 1);
    repeat (400) @(negedge clk);
    chk(mod_rst && !ref_en, "R2", "no clocks", int'(ref_en), 0);

    // master only
    run_m = 1;
    repeat (3000) @(negedge clk);
    chk(mod_rst && !ref_en, "R2", "master clock only", int'(ref_en), 0);

    // 256, 5 V
    start_clk(128, 1, 0, 1, 0, 2'd0);
    wait_ev(1, "R3");
    stop_clk(0, "R7");

    // restart at 512, 3 V: new ratio and supply adopted
    start_clk(256, 0, 1, 1, 0, 2'd2);
    wait_ev(2, "R8");
    stop_clk(1, "R7");

    // 384 with both flags: high range wins
    start_clk(192, 1, 1, 1, 0, 2'd1);
    wait_ev(3, "R5");
    stop_clk(1, "R7");

    // unsupported ratio 300
    start_clk(150, 1, 0, 1, 1, 2'd3);
    wait_ev(4, "R9");
    repeat (3000) @(negedge clk);
    chk(rerr && !ref_en && !ready, "R9", "stays down on bad ratio", int'(ref_en), 0);
    stop_clk(1, "R7");

    // no supply flag: reference only
    start_clk(128, 0, 0, 0, 0, 2'd0);
    n = 0;
    while (!ref_en && n < 10000) begin @(negedge clk); n++; end
    chk(ref_en, "R10", "reference on", int'(ref_en), 1);
    chk(!rerr, "R9", "error cleared on restart", int'(rerr), 0);
    repeat (3000) @(negedge clk);
    chk(ref_en && !dac_en && !ready, "R10", "converters held off", int'(dac_en), 0);
    start_clk(128, 1, 0, 1, 0, 2'd0);
    wait_ev(5, "R10");
    stop_clk(0, "R7");

    // supply re-sampled on restart
    start_clk(256, 0, 1, 1, 0, 2'd2);
    wait_ev(6, "R8");
    chk(sup5 == 1'b0 && ratio == 2'd2, "R8", "re-detected mode", int'(sup5), 0);

    chk(exp_q.size() == 0, "R3", "pending expectations", exp_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    end
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    end
    $finish;
  end
endmodule